// File: doc/BRIEF.md
# Two-Hop Routed Matrix Multiply Core

This block controls a square grid of compute cells that together form C = A × B for two N×N signed matrices. Operands come in as indexed tokens. A sign token on the write-command bus sets whether element (row, col) of A or of B is negative. A magnitude token on the data-in bus sets its absolute value. Every write token passes two registered router hops before it lands in the cell storage. A go command then starts processing. Each cell (i, j) accumulates the dot product of row i of A with column j of B, and the result stays in that cell until the next go.

Results are read back with two commands on the read-command bus. An index-carrying fetch moves C[row][col] into the second hop. An index-free output command then has the first hop pull that value and present it on the data-out bus for a single cycle. A phase sequencer (idle, sign loading, data loading, processing, fetch-ready, output-pending) admits only the commands that suit the current phase. Commands that arrive in the wrong phase, or that carry an index outside the grid, are dropped and reported on one-cycle flag outputs.

Top module: `dual_hop_matrix_core`

## Requirements
- R1: A write-command token with op=0 sets the sign of element (row, col) of A (mat=0) or B (mat=1); neg=1 marks it negative. It is accepted from idle, from sign loading or from fetch-ready, and it moves the core to sign loading.
- R2: A data-in token sets the unsigned magnitude of element (row, col) of A (mat=0) or B (mat=1). It is accepted in sign loading or data loading, and it moves the core to data loading.
- R3: A write-command token with op=1 (go), accepted in data loading, makes every C[i][j] equal the sum over k of A[i][k]·B[k][j] with signed operands. Results stay readable, unchanged by reads, until the next go.
- R4: While processing, all three input ready outputs are low. Processing ends once both write hops have drained and N accumulate cycles have run.
- R5: A read is a fetch token (op=0, with row and col) followed by an output token (op=1). dout_valid_o is high for exactly one cycle, the cycle after the output token is accepted, with dout_data_o = C[row][col]. rd_cmd_ready_o is low while dout_ready_i is low and in the cycle after a fetch is accepted.
- R6: A token accepted in a phase that does not allow it is dropped, and err_phase_o is high in the following cycle only. This covers data or go before loading, go during sign loading, sign during data loading, a read outside the read phases, and an output token with no fetch held.
- R7: A sign, data or fetch token with row ≥ N or col ≥ N is dropped without changing any stored value or the phase, and err_range_o is high in the following cycle only.
- R8: Only one read may be outstanding. A fetch accepted while a fetched value is held raises err_phase_o, and the held value is still the one delivered by the next output token.
- R9: At most one token is taken per cycle, with priority write-command over data-in over read-command, shown by din_ready_o and rd_cmd_ready_o going low while a higher-priority valid is present.
- R10: After reset the core is idle, dout_valid_o and both flags are low, all input readies are high (read ready also needs dout_ready_i), and any read token is a phase error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cmd_valid_i | input | 1 | Write-command token valid |
| wr_cmd_ready_o | output | 1 | Write-command token accepted |
| wr_cmd_op_i | input | 1 | 0 = sign token, 1 = go |
| wr_cmd_mat_i | input | 1 | 0 = matrix A, 1 = matrix B |
| wr_cmd_neg_i | input | 1 | Sign of the element, 1 = negative |
| wr_cmd_row_i | input | IDX_W | Element row |
| wr_cmd_col_i | input | IDX_W | Element column |
| din_valid_i | input | 1 | Data-in token valid |
| din_ready_o | output | 1 | Data-in token accepted |
| din_mat_i | input | 1 | 0 = matrix A, 1 = matrix B |
| din_row_i | input | IDX_W | Element row |
| din_col_i | input | IDX_W | Element column |
| din_mag_i | input | MAG_W | Element magnitude |
| rd_cmd_valid_i | input | 1 | Read-command token valid |
| rd_cmd_ready_o | output | 1 | Read-command token accepted |
| rd_cmd_op_i | input | 1 | 0 = fetch by index, 1 = output held value |
| rd_cmd_row_i | input | IDX_W | Result row for fetch |
| rd_cmd_col_i | input | IDX_W | Result column for fetch |
| dout_valid_o | output | 1 | One-cycle result strobe |
| dout_ready_i | input | 1 | Sink can take a result |
| dout_data_o | output | ACC_W | Signed result element |
| err_phase_o | output | 1 | Out-of-phase token dropped |
| err_range_o | output | 1 | Out-of-range index dropped |

## Verification
The bench loads four operand sets chosen to stress the arithmetic: all-positive, mixed signs with zeros, full-magnitude operands whose sums reach the most negative accumulator values, and a mix of both. It sends the go command on the cycle right after the last data token, so a core that starts accumulating before the two write hops drain would use a stale operand and read back a wrong product. An out-of-range column of 3 on a 3×3 grid points at element (1,0) when the index is flattened. A core that skipped the range check would corrupt that element, and the unchanged results read back after a new go would differ. A second fetch while one is held, an output token with no fetch, a reset in mid-operation and simultaneous valids on all three input buses check that a sequencer which loses track of its phase would deliver the wrong element, strobe the output twice or accept two tokens at once.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WSIGN  = 3'd1,
    S_WDATA  = 3'd2,
    S_PROC   = 3'd3,
    S_RFETCH = 3'd4,
    S_ROUT   = 3'd5
  } phase_e;

  localparam logic OP_SIGN  = 1'b0;
  localparam logic OP_GO    = 1'b1;
  localparam logic RD_FETCH = 1'b0;
  localparam logic RD_OUT   = 1'b1;
endpackage

// File: rtl/mc_write_path.sv
module mc_write_path #(
  parameter int IDX_W = 2,
  parameter int MAG_W = 8,
  parameter int HOPS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             is_data_i,
  input  logic             mat_i,
  input  logic             neg_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] col_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             busy_o,
  output logic             st_we_o,
  output logic             st_is_data_o,
  output logic             st_mat_o,
  output logic             st_neg_o,
  output logic [IDX_W-1:0] st_row_o,
  output logic [IDX_W-1:0] st_col_o,
  output logic [MAG_W-1:0] st_mag_o
);
  typedef struct packed {
    logic             is_data;
    logic             mat;
    logic             neg;
    logic [IDX_W-1:0] row;
    logic [IDX_W-1:0] col;
    logic [MAG_W-1:0] mag;
  } tok_t;

  tok_t tok_in;
  tok_t hop_q [HOPS];
  logic vld_q [HOPS];

  assign tok_in = '{is_data: is_data_i, mat: mat_i, neg: neg_i,
                    row: row_i, col: col_i, mag: mag_i};

  for (genvar h = 0; h < HOPS; h++) begin : g_hop
    if (h == 0) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          hop_q[0] <= '0;
        end else begin
          vld_q[0] <= push_i;
          if (push_i) hop_q[0] <= tok_in;
        end
      end
    end else begin : g_fwd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[h] <= 1'b0;
          hop_q[h] <= '0;
        end else begin
          vld_q[h] <= vld_q[h-1];
          if (vld_q[h-1]) hop_q[h] <= hop_q[h-1];
        end
      end
    end
  end

  always_comb begin
    busy_o = 1'b0;
    for (int h = 0; h < HOPS; h++) busy_o = busy_o | vld_q[h];
  end

  assign st_we_o      = vld_q[HOPS-1];
  assign st_is_data_o = hop_q[HOPS-1].is_data;
  assign st_mat_o     = hop_q[HOPS-1].mat;
  assign st_neg_o     = hop_q[HOPS-1].neg;
  assign st_row_o     = hop_q[HOPS-1].row;
  assign st_col_o     = hop_q[HOPS-1].col;
  assign st_mag_o     = hop_q[HOPS-1].mag;
endmodule

// File: rtl/mc_operand_store.sv
module mc_operand_store #(
  parameter  int N     = 3,
  parameter  int MAG_W = 8,
  parameter  int IDX_W = 2,
  localparam int CELLS = N * N,
  localparam int CW    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    is_data_i,
  input  logic                    mat_i,
  input  logic                    neg_i,
  input  logic [IDX_W-1:0]        row_i,
  input  logic [IDX_W-1:0]        col_i,
  input  logic [MAG_W-1:0]        mag_i,
  output logic signed [MAG_W:0]   a_val_o [CELLS],
  output logic signed [MAG_W:0]   b_val_o [CELLS]
);
  logic [MAG_W-1:0] mag_q [2][CELLS];
  logic             neg_q [2][CELLS];
  logic [CW-1:0]    idx;

  assign idx = CW'(int'(row_i) * N + int'(col_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < CELLS; c++) begin
          mag_q[m][c] <= '0;
          neg_q[m][c] <= 1'b0;
        end
    end else if (we_i) begin
      if (is_data_i) mag_q[mat_i][idx] <= mag_i;
      else           neg_q[mat_i][idx] <= neg_i;
    end
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_val
    assign a_val_o[c] = neg_q[0][c] ? -$signed({1'b0, mag_q[0][c]}) : $signed({1'b0, mag_q[0][c]});
    assign b_val_o[c] = neg_q[1][c] ? -$signed({1'b0, mag_q[1][c]}) : $signed({1'b0, mag_q[1][c]});
  end
endmodule

// File: rtl/mc_mac_cell.sv
module mc_mac_cell #(
  parameter int MAG_W = 8,
  parameter int ACC_W = 19
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [MAG_W:0]   a_i,
  input  logic signed [MAG_W:0]   b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] prod;

  assign prod = ACC_W'(a_i) * ACC_W'(b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + prod;
  end
endmodule

// File: rtl/mc_read_path.sv
module mc_read_path #(
  parameter  int N     = 3,
  parameter  int IDX_W = 2,
  parameter  int ACC_W = 19,
  localparam int CELLS = N * N,
  localparam int CW    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_i,
  input  logic [IDX_W-1:0]        row_i,
  input  logic [IDX_W-1:0]        col_i,
  input  logic signed [ACC_W-1:0] res_i [CELLS],
  input  logic                    pull_i,
  output logic                    busy_o,
  output logic                    dout_valid_o,
  output logic signed [ACC_W-1:0] dout_data_o
);
  logic                    h1_vld_q;
  logic [CW-1:0]           h1_idx_q;
  logic signed [ACC_W-1:0] h2_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_vld_q     <= 1'b0;
      h1_idx_q     <= '0;
      h2_data_q    <= '0;
      dout_valid_o <= 1'b0;
      dout_data_o  <= '0;
    end else begin
      h1_vld_q <= fetch_i;
      if (fetch_i) h1_idx_q <= CW'(int'(row_i) * N + int'(col_i));
      // hop 2 captures the addressed cell one cycle after the request
      if (h1_vld_q) h2_data_q <= res_i[h1_idx_q];
      // hop 1 pulls the held value onto the output bus
      dout_valid_o <= pull_i;
      if (pull_i) dout_data_o <= h2_data_q;
    end
  end

  assign busy_o = h1_vld_q;
endmodule

// File: rtl/dual_hop_matrix_core.sv
module dual_hop_matrix_core
  import mc_pkg::*;
#(
  parameter  int N     = 3,
  parameter  int MAG_W = 8,
  localparam int IDX_W = $clog2(N + 1),
  localparam int ACC_W = 2 * MAG_W + ((N > 1) ? $clog2(N) : 1) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_cmd_valid_i,
  output logic                    wr_cmd_ready_o,
  input  logic                    wr_cmd_op_i,
  input  logic                    wr_cmd_mat_i,
  input  logic                    wr_cmd_neg_i,
  input  logic [IDX_W-1:0]        wr_cmd_row_i,
  input  logic [IDX_W-1:0]        wr_cmd_col_i,
  input  logic                    din_valid_i,
  output logic                    din_ready_o,
  input  logic                    din_mat_i,
  input  logic [IDX_W-1:0]        din_row_i,
  input  logic [IDX_W-1:0]        din_col_i,
  input  logic [MAG_W-1:0]        din_mag_i,
  input  logic                    rd_cmd_valid_i,
  output logic                    rd_cmd_ready_o,
  input  logic                    rd_cmd_op_i,
  input  logic [IDX_W-1:0]        rd_cmd_row_i,
  input  logic [IDX_W-1:0]        rd_cmd_col_i,
  output logic                    dout_valid_o,
  input  logic                    dout_ready_i,
  output logic signed [ACC_W-1:0] dout_data_o,
  output logic                    err_phase_o,
  output logic                    err_range_o
);
  localparam int CELLS = N * N;
  localparam int K_W   = (N > 1) ? $clog2(N) : 1;

  phase_e state_q, state_d;
  logic   wr_fire, din_fire, rd_fire, base_rdy, rd_busy, wr_busy;
  logic   push, fetch, pull, clr, mac_en, k_last;
  logic   err_ph_d, err_rg_d;
  logic [K_W-1:0] k_q;

  logic             st_we, st_is_data, st_mat, st_neg;
  logic [IDX_W-1:0] st_row, st_col;
  logic [MAG_W-1:0] st_mag;
  logic signed [MAG_W:0]   a_val [CELLS];
  logic signed [MAG_W:0]   b_val [CELLS];
  logic signed [ACC_W-1:0] res   [CELLS];

  function automatic logic in_grid(input logic [IDX_W-1:0] r, input logic [IDX_W-1:0] c);
    return (int'(r) < N) && (int'(c) < N);
  endfunction

  // one token per cycle: write command, then data, then read
  assign base_rdy       = (state_q != S_PROC);
  assign wr_cmd_ready_o = base_rdy;
  assign din_ready_o    = base_rdy && !wr_cmd_valid_i;
  assign rd_cmd_ready_o = base_rdy && !wr_cmd_valid_i && !din_valid_i && dout_ready_i && !rd_busy;

  assign wr_fire  = wr_cmd_valid_i && wr_cmd_ready_o;
  assign din_fire = din_valid_i && din_ready_o;
  assign rd_fire  = rd_cmd_valid_i && rd_cmd_ready_o;

  assign mac_en = (state_q == S_PROC) && !wr_busy;
  assign k_last = (k_q == K_W'(N - 1));

  always_comb begin
    state_d  = state_q;
    push     = 1'b0;
    fetch    = 1'b0;
    pull     = 1'b0;
    clr      = 1'b0;
    err_ph_d = 1'b0;
    err_rg_d = 1'b0;
    if (wr_fire) begin
      if (wr_cmd_op_i == OP_GO) begin
        if (state_q == S_WDATA) begin
          state_d = S_PROC;
          clr     = 1'b1;
        end else err_ph_d = 1'b1;
      end else if (!(state_q inside {S_IDLE, S_WSIGN, S_RFETCH})) err_ph_d = 1'b1;
      else if (!in_grid(wr_cmd_row_i, wr_cmd_col_i)) err_rg_d = 1'b1;
      else begin
        push    = 1'b1;
        state_d = S_WSIGN;
      end
    end else if (din_fire) begin
      if (!(state_q inside {S_WSIGN, S_WDATA})) err_ph_d = 1'b1;
      else if (!in_grid(din_row_i, din_col_i)) err_rg_d = 1'b1;
      else begin
        push    = 1'b1;
        state_d = S_WDATA;
      end
    end else if (rd_fire) begin
      if (rd_cmd_op_i == RD_FETCH) begin
        if (state_q != S_RFETCH) err_ph_d = 1'b1;
        else if (!in_grid(rd_cmd_row_i, rd_cmd_col_i)) err_rg_d = 1'b1;
        else begin
          fetch   = 1'b1;
          state_d = S_ROUT;
        end
      end else begin
        if (state_q == S_ROUT) begin
          pull    = 1'b1;
          state_d = S_RFETCH;
        end else err_ph_d = 1'b1;
      end
    end
    if (mac_en && k_last) state_d = S_RFETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      k_q         <= '0;
      err_phase_o <= 1'b0;
      err_range_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      err_phase_o <= err_ph_d;
      err_range_o <= err_rg_d;
      if (clr)                  k_q <= '0;
      else if (mac_en)          k_q <= k_last ? '0 : k_q + 1'b1;
    end
  end

  mc_write_path #(.IDX_W(IDX_W), .MAG_W(MAG_W), .HOPS(2)) u_wpath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .is_data_i    (din_fire),
    .mat_i        (wr_fire ? wr_cmd_mat_i : din_mat_i),
    .neg_i        (wr_cmd_neg_i),
    .row_i        (wr_fire ? wr_cmd_row_i : din_row_i),
    .col_i        (wr_fire ? wr_cmd_col_i : din_col_i),
    .mag_i        (din_mag_i),
    .busy_o       (wr_busy),
    .st_we_o      (st_we),
    .st_is_data_o (st_is_data),
    .st_mat_o     (st_mat),
    .st_neg_o     (st_neg),
    .st_row_o     (st_row),
    .st_col_o     (st_col),
    .st_mag_o     (st_mag)
  );

  mc_operand_store #(.N(N), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (st_we),
    .is_data_i (st_is_data),
    .mat_i     (st_mat),
    .neg_i     (st_neg),
    .row_i     (st_row),
    .col_i     (st_col),
    .mag_i     (st_mag),
    .a_val_o   (a_val),
    .b_val_o   (b_val)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [MAG_W:0] a_sel, b_sel;
      assign a_sel = a_val[i * N + int'(k_q)];
      assign b_sel = b_val[int'(k_q) * N + j];
      mc_mac_cell #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .en_i   (mac_en),
        .a_i    (a_sel),
        .b_i    (b_sel),
        .acc_o  (res[i * N + j])
      );
    end
  end

  mc_read_path #(.N(N), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_rpath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_i      (fetch),
    .row_i        (rd_cmd_row_i),
    .col_i        (rd_cmd_col_i),
    .res_i        (res),
    .pull_i       (pull),
    .busy_o       (rd_busy),
    .dout_valid_o (dout_valid_o),
    .dout_data_o  (dout_data_o)
  );
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input phase_e state_i,
  input logic   wr_cmd_valid_i,
  input logic   wr_cmd_ready_o,
  input logic   din_valid_i,
  input logic   din_ready_o,
  input logic   rd_cmd_valid_i,
  input logic   rd_cmd_ready_o,
  input logic   rd_cmd_op_i,
  input logic   dout_valid_o,
  input logic   err_phase_o,
  input logic   err_range_o
);
  logic rd_fire;
  assign rd_fire = rd_cmd_valid_i && rd_cmd_ready_o;

  a_r5_dout_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |=> !dout_valid_o);

  a_r5_dout_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> $past(rd_fire && rd_cmd_op_i == RD_OUT && state_i == S_ROUT));

  a_r4_proc_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_PROC |-> !wr_cmd_ready_o && !din_ready_o && !rd_cmd_ready_o);

  a_r8_second_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && rd_cmd_op_i == RD_FETCH && state_i == S_ROUT) |=> err_phase_o);

  a_r9_one_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_cmd_valid_i && wr_cmd_ready_o, din_valid_i && din_ready_o, rd_fire}));

  a_r7_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_phase_o, err_range_o}));
endmodule

bind dual_hop_matrix_core mc_core_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_i        (state_q),
  .wr_cmd_valid_i (wr_cmd_valid_i),
  .wr_cmd_ready_o (wr_cmd_ready_o),
  .din_valid_i    (din_valid_i),
  .din_ready_o    (din_ready_o),
  .rd_cmd_valid_i (rd_cmd_valid_i),
  .rd_cmd_ready_o (rd_cmd_ready_o),
  .rd_cmd_op_i    (rd_cmd_op_i),
  .dout_valid_o   (dout_valid_o),
  .err_phase_o    (err_phase_o),
  .err_range_o    (err_range_o)
);

// File: tb/sim_dual_hop_matrix_core.sv
`timescale 1ns/1ps
module sim_dual_hop_matrix_core;
  localparam int N     = 3;
  localparam int MAG_W = 8;
  localparam int IDX_W = 2;
  localparam int ACC_W = 19;
  localparam int NV    = 4;

  // A row-major (9 entries) then B row-major (9 entries)
  localparam int VEC [NV][18] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8, 9,  9, 8, 7, 6, 5, 4, 3, 2, 1},
    '{-1, 2, -3, 4, -5, 6, -7, 8, -9,  2, -1, 0, -3, 4, 1, 5, 0, -2},
    '{255, 255, 255, 255, 255, 255, 255, 255, 255,
      -255, -255, -255, -255, -255, -255, -255, -255, -255},
    '{255, -255, 0, 1, 0, -1, 100, -50, 25,  -255, 0, 3, -255, 7, -1, 0, 2, 2}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_cmd_valid_i = 0, wr_cmd_op_i = 0, wr_cmd_mat_i = 0, wr_cmd_neg_i = 0;
  logic [IDX_W-1:0] wr_cmd_row_i = '0, wr_cmd_col_i = '0;
  logic din_valid_i = 0, din_mat_i = 0;
  logic [IDX_W-1:0] din_row_i = '0, din_col_i = '0;
  logic [MAG_W-1:0] din_mag_i = '0;
  logic rd_cmd_valid_i = 0, rd_cmd_op_i = 0;
  logic [IDX_W-1:0] rd_cmd_row_i = '0, rd_cmd_col_i = '0;
  logic dout_ready_i = 1'b1;
  logic wr_cmd_ready_o, din_ready_o, rd_cmd_ready_o, dout_valid_o, err_phase_o, err_range_o;
  logic signed [ACC_W-1:0] dout_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic eph, erg, dv;
  logic signed [ACC_W-1:0] dd;

  always #2 clk_i = ~clk_i;

  dual_hop_matrix_core #(.N(N), .MAG_W(MAG_W)) u0 (.*);

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_c(input int t, input int r, input int c);
    int s = 0;
    for (int k = 0; k < N; k++) s += VEC[t][r * N + k] * VEC[t][N * N + k * N + c];
    return s;
  endfunction

  // all token tasks start and end on a falling edge
  task automatic wr_tok(input logic op, input logic mat, input logic neg, input int r, input int c);
    wr_cmd_valid_i = 1; wr_cmd_op_i = op; wr_cmd_mat_i = mat; wr_cmd_neg_i = neg;
    wr_cmd_row_i = IDX_W'(r); wr_cmd_col_i = IDX_W'(c);
    #1;
    while (!wr_cmd_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    wr_cmd_valid_i = 0;
    eph = err_phase_o; erg = err_range_o;
  endtask

  task automatic din_tok(input logic mat, input int r, input int c, input int mag);
    din_valid_i = 1; din_mat_i = mat; din_row_i = IDX_W'(r); din_col_i = IDX_W'(c);
    din_mag_i = MAG_W'(mag);
    #1;
    while (!din_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    din_valid_i = 0;
    eph = err_phase_o; erg = err_range_o;
  endtask

  task automatic rd_tok(input logic op, input int r, input int c);
    rd_cmd_valid_i = 1; rd_cmd_op_i = op; rd_cmd_row_i = IDX_W'(r); rd_cmd_col_i = IDX_W'(c);
    #1;
    while (!rd_cmd_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    rd_cmd_valid_i = 0;
    eph = err_phase_o; erg = err_range_o; dv = dout_valid_o; dd = dout_data_o;
  endtask

  task automatic load_vec(input int t);
    for (int e = 0; e < 2 * N * N; e++)
      wr_tok(1'b0, e >= N * N, VEC[t][e] < 0, (e % (N * N)) / N, e % N);
    for (int e = 0; e < 2 * N * N; e++)
      din_tok(e >= N * N, (e % (N * N)) / N, e % N,
              (VEC[t][e] < 0) ? -VEC[t][e] : VEC[t][e]);
    wr_tok(1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic read_chk(input string tag, input int r, input int c, input int exp);
    rd_tok(1'b0, r, c);
    rd_tok(1'b1, 0, 0);
    chk({tag, " dout value"}, dv ? int'(dd) : 32'h7fff_ffff, exp);
    @(negedge clk_i);
    chk({tag, " dout one cycle"}, int'(dout_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    // R10 reset state
    chk("R10 dout_valid", int'(dout_valid_o), 0);
    chk("R10 err flags", int'({err_phase_o, err_range_o}), 0);
    chk("R10 readies", int'({wr_cmd_ready_o, din_ready_o, rd_cmd_ready_o}), 7);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R1 R2 R3 R4 R5
    for (int t = 0; t < NV; t++) begin
      load_vec(t);
      chk("R4 ready low in processing", int'({wr_cmd_ready_o, din_ready_o, rd_cmd_ready_o}), 0);
      for (int e = 0; e < N * N; e++)
        read_chk("R3 product", e / N, e % N, exp_c(t, e / N, e % N));
    end

    // R8: second fetch rejected, held value survives
    rd_tok(1'b0, 0, 0);
    chk("R8 first fetch clean", int'(eph), 0);
    rd_tok(1'b0, 1, 1);
    chk("R8 second fetch flagged", int'(eph), 1);
    rd_tok(1'b1, 0, 0);
    chk("R8 held value delivered", dv ? int'(dd) : 32'h7fff_ffff, exp_c(3, 0, 0));

    // R6: output with nothing held
    rd_tok(1'b1, 0, 0);
    chk("R6 output without fetch flag", int'(eph), 1);
    chk("R6 output without fetch no data", int'(dv), 0);

    // R7: out-of-range fetch keeps phase
    rd_tok(1'b0, 3, 0);
    chk("R7 fetch range flag", int'(erg), 1);
    chk("R7 fetch range not phase", int'(eph), 0);
    rd_tok(1'b1, 0, 0);
    chk("R7 phase unchanged after range drop", int'(eph), 1);

    // R7: out-of-range writes leave operands alone
    wr_tok(1'b0, 1'b0, 1'b0, 0, 0);
    chk("R1 sign from fetch-ready", int'(eph | erg), 0);
    wr_tok(1'b0, 1'b0, 1'b1, 0, 3);
    chk("R7 sign range flag", int'(erg), 1);
    din_tok(1'b0, 0, 3, 99);
    chk("R7 data range flag", int'(erg), 1);
    din_tok(1'b1, 2, 2, 2);
    chk("R2 data accepted", int'(eph | erg), 0);
    wr_tok(1'b0, 1'b1, 1'b0, 1, 1);
    chk("R6 sign in data phase", int'(eph), 1);
    wr_tok(1'b1, 1'b0, 1'b0, 0, 0);
    chk("R4 ready low after go", int'({wr_cmd_ready_o, din_ready_o, rd_cmd_ready_o}), 0);
    for (int e = 0; e < N * N; e++)
      read_chk("R7 operands unchanged", e / N, e % N, exp_c(3, e / N, e % N));
    read_chk("R3 result persists", 2, 1, exp_c(3, 2, 1));

    // R5: sink not ready stalls reads
    dout_ready_i = 1'b0;
    rd_cmd_valid_i = 1; rd_cmd_op_i = 1'b0;
    #1;
    chk("R5 read ready follows sink", int'(rd_cmd_ready_o), 0);
    @(negedge clk_i);
    rd_cmd_valid_i = 0;
    dout_ready_i = 1'b1;

    // R10: reset mid-run
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    #1;
    chk("R10 mid-run reset outputs", int'({dout_valid_o, err_phase_o, err_range_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: all three valid together
    wr_cmd_valid_i = 1; wr_cmd_op_i = 1'b1; din_valid_i = 1; rd_cmd_valid_i = 1;
    #1;
    chk("R9 din yields to write command", int'(din_ready_o), 0);
    chk("R9 read yields", int'(rd_cmd_ready_o), 0);
    @(negedge clk_i);
    wr_cmd_valid_i = 0; din_valid_i = 0; rd_cmd_valid_i = 0;
    chk("R6 go while idle", int'(err_phase_o), 1);

    rd_tok(1'b0, 0, 0);
    chk("R10 fetch after reset rejected", int'(eph), 1);
    rd_tok(1'b1, 0, 0);
    chk("R10 output after reset rejected", int'(eph), 1);
    chk("R10 no data after reset", int'(dv), 0);
    din_tok(1'b0, 0, 0, 5);
    chk("R6 data while idle", int'(eph), 1);
    wr_tok(1'b0, 1'b0, 1'b0, 0, 0);
    wr_tok(1'b1, 1'b0, 1'b0, 0, 0);
    chk("R6 go during sign phase", int'(eph), 1);
    @(negedge clk_i);
    chk("R6 flag one cycle", int'(err_phase_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule